// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port

This block is an 8-bit general-purpose I/O port attached to a simple memory-mapped register bus. Software uses two stored registers and one view. A direction register chooses, pin by pin, whether the port drives the pin. A data register holds the values that are driven. A port view reports the pin states. The block drives a per-pin output enable and output value. It samples the pin inputs through a synchronizer.

Bus writes are single-cycle strobes with an address and write data. The block takes a write on the rising clock edge where the strobe is high and the address matches one of its registers. Reads are combinational from the address, and there is no handshake in either direction. Two standby inputs change how the registers behave. Hardware standby wipes both stored registers and releases every pin. Software standby freezes the registers exactly as they are.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, every pin_oe bit and every pin_out bit is 0, and a read of the data register at 0xFF61 returns 0x00.
- R2: A write to address 0xFE21 loads the direction register. From the next clock edge, pin_oe bit i is 1 (pin drives) where written bit i was 1, and 0 (pin is an input) where it was 0.
- R3: The direction register cannot be read back. A read of 0xFE21 always returns 0xFF, whatever the register holds.
- R4: A write to 0xFF61 loads the data register. A read of 0xFF61 returns the stored byte.
- R5: A read of 0xFF51 returns, for each bit i, the data-register bit when direction bit i is 1, and the synchronized pin_in bit when direction bit i is 0.
- R6: A change on pin_in shows in the 0xFF51 read after exactly two rising clock edges, and not after one.
- R7: While hw_stby is 1, all pin_oe bits are 0 in the same cycle. Both registers are cleared to 0x00 at each clock edge, and bus writes are ignored.
- R8: While sw_stby is 1 and hw_stby is 0, bus writes are ignored, and both registers keep their contents.
- R9: Writes to 0xFF51 or to any unmapped address change neither register. A read of an unmapped address returns 0x00.
- R10: Outside hardware standby, pin_oe equals the direction register and pin_out equals the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_stby | input | 1 | Hardware standby: clears the registers and releases the pins |
| sw_stby | input | 1 | Software standby: freezes the registers |
| bus_addr | input | 16 | Low 16 bits of the bus address |
| bus_wr | input | 1 | Write strobe, qualified by bus_addr |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pin_in | input | 8 | Asynchronous pin levels |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin output value |

## Verification
The assertions check several behaviours on every cycle. They check that the pins are released during hardware standby and that the data register is clear on the edge after it. They check the all-ones read of the direction address and the zero read of unmapped addresses. They also check that a data write lands on the next edge, and that the output value holds through software standby. Some behaviours can only be shown by the bench's scenarios. One is the per-bit merge of driven values and sampled inputs in the port read, swept over all 256 direction patterns. Another is the exact two-edge input latency. A third is that writes to the read-only and unmapped addresses are discarded.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Register selected by the current bus address
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_DATA = 2'd2,
    SEL_PORT = 2'd3
  } gpio_sel_e;

  localparam int unsigned GPIO_ADDR_W  = 16;
  localparam int unsigned GPIO_PINS    = 8;
  localparam logic [15:0] GPIO_DIR_OFS  = 16'hFE21;
  localparam logic [15:0] GPIO_DATA_OFS = 16'hFF61;
  localparam logic [15:0] GPIO_PORT_OFS = 16'hFF51;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int unsigned ADDR_W    = GPIO_ADDR_W,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = GPIO_DIR_OFS,
  parameter logic [ADDR_W-1:0] DATA_ADDR = GPIO_DATA_OFS,
  parameter logic [ADDR_W-1:0] PORT_ADDR = GPIO_PORT_OFS
) (
  input  logic [ADDR_W-1:0] addr,
  output gpio_sel_e         sel
);

  always_comb begin
    if (addr == DIR_ADDR)       sel = SEL_DIR;
    else if (addr == DATA_ADDR) sel = SEL_DATA;
    else if (addr == PORT_ADDR) sel = SEL_PORT;
    else                        sel = SEL_NONE;
  end

endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
  import gpio_pkg::*;
#(
  parameter int unsigned PINS = GPIO_PINS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_stby,
  input  logic            sw_stby,
  input  logic            wr,
  input  gpio_sel_e       sel,
  input  logic [PINS-1:0] wdata,
  output logic [PINS-1:0] dir_q,
  output logic [PINS-1:0] data_q
);

  logic wr_ok;
  assign wr_ok = wr & ~sw_stby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      data_q <= '0;
    end else if (hw_stby) begin
      dir_q  <= '0;
      data_q <= '0;
    end else if (wr_ok) begin
      if (sel == SEL_DIR)  dir_q  <= wdata;
      if (sel == SEL_DATA) data_q <= wdata;
    end
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
  import gpio_pkg::*;
#(
  parameter int unsigned PINS   = GPIO_PINS,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] d,
  output logic [PINS-1:0] q
);

  logic [STAGES-1:0][PINS-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
  import gpio_pkg::*;
#(
  parameter int unsigned PINS = GPIO_PINS
) (
  input  gpio_sel_e       sel,
  input  logic [PINS-1:0] dir_q,
  input  logic [PINS-1:0] data_q,
  input  logic [PINS-1:0] pins_sync,
  output logic [PINS-1:0] rdata
);

  logic [PINS-1:0] port_view;

  for (genvar i = 0; i < PINS; i++) begin : g_bit
    assign port_view[i] = dir_q[i] ? data_q[i] : pins_sync[i];
  end

  always_comb begin
    case (sel)
      SEL_DIR:  rdata = '1;
      SEL_DATA: rdata = data_q;
      SEL_PORT: rdata = port_view;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_pkg::*;
#(
  parameter int unsigned ADDR_W      = GPIO_ADDR_W,
  parameter int unsigned PINS        = GPIO_PINS,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = GPIO_DIR_OFS,
  parameter logic [ADDR_W-1:0] DATA_ADDR = GPIO_DATA_OFS,
  parameter logic [ADDR_W-1:0] PORT_ADDR = GPIO_PORT_OFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [PINS-1:0]   bus_wdata,
  output logic [PINS-1:0]   bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_oe,
  output logic [PINS-1:0]   pin_out
);

  gpio_sel_e       sel;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] data_q;
  logic [PINS-1:0] pins_sync;

  gpio_addr_dec #(
    .ADDR_W   (ADDR_W),
    .DIR_ADDR (DIR_ADDR),
    .DATA_ADDR(DATA_ADDR),
    .PORT_ADDR(PORT_ADDR)
  ) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  gpio_ctl_regs #(.PINS(PINS)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .hw_stby(hw_stby),
    .sw_stby(sw_stby),
    .wr     (bus_wr),
    .sel    (sel),
    .wdata  (bus_wdata),
    .dir_q  (dir_q),
    .data_q (data_q)
  );

  gpio_in_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in),
    .q    (pins_sync)
  );

  gpio_rd_mux #(.PINS(PINS)) u_rd (
    .sel      (sel),
    .dir_q    (dir_q),
    .data_q   (data_q),
    .pins_sync(pins_sync),
    .rdata    (bus_rdata)
  );

  assign pin_oe  = hw_stby ? '0 : dir_q;
  assign pin_out = data_q;

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk
  import gpio_pkg::*;
#(
  parameter int unsigned ADDR_W = GPIO_ADDR_W,
  parameter int unsigned PINS   = GPIO_PINS,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = GPIO_DIR_OFS,
  parameter logic [ADDR_W-1:0] DATA_ADDR = GPIO_DATA_OFS,
  parameter logic [ADDR_W-1:0] PORT_ADDR = GPIO_PORT_OFS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hw_stby,
  input logic              sw_stby,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [PINS-1:0]   bus_wdata,
  input logic [PINS-1:0]   bus_rdata,
  input logic [PINS-1:0]   pin_oe,
  input logic [PINS-1:0]   pin_out
);

  logic unmapped;
  assign unmapped = (bus_addr != DIR_ADDR) && (bus_addr != DATA_ADDR) &&
                    (bus_addr != PORT_ADDR);

  p_hw_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |-> (pin_oe == '0));

  p_hw_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (pin_out == '0));

  p_sw_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby) |=> $stable(pin_out));

  p_dir_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == DIR_ADDR) |-> (bus_rdata == '1));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped |-> (bus_rdata == '0));

  p_data_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == DATA_ADDR && !hw_stby && !sw_stby)
      |=> (pin_out == $past(bus_wdata)));

  p_data_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == DATA_ADDR) |-> (bus_rdata == pin_out));

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
  .ADDR_W   (ADDR_W),
  .PINS     (PINS),
  .DIR_ADDR (DIR_ADDR),
  .DATA_ADDR(DATA_ADDR),
  .PORT_ADDR(PORT_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hw_stby  (hw_stby),
  .sw_stby  (sw_stby),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pin_oe   (pin_oe),
  .pin_out  (pin_out)
);

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb;

  localparam logic [15:0] A_DIR  = 16'hFE21;
  localparam logic [15:0] A_DATA = 16'hFF61;
  localparam logic [15:0] A_PORT = 16'hFF51;
  localparam logic [15:0] A_NONE = 16'h1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_stby = 1'b0;
  logic        sw_stby = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [7:0]  pin_in = 8'h00;
  logic [7:0]  pin_oe;
  logic [7:0]  pin_out;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_port_regs u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .hw_stby  (hw_stby),
    .sw_stby  (sw_stby),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pin_in   (pin_in),
    .pin_oe   (pin_oe),
    .pin_out  (pin_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    bus_read(A_DATA, rd); chk("R1 data read", rd, 8'h00);

    // R3: direction read is all ones
    bus_read(A_DIR, rd); chk("R3 dir read", rd, 8'hFF);

    // R9: writes to port view and unmapped addresses are dropped
    bus_write(A_PORT, 8'h77);
    bus_write(A_NONE, 8'h99);
    chk("R9 pin_oe", pin_oe, 8'h00);
    bus_read(A_DATA, rd); chk("R9 data", rd, 8'h00);
    bus_read(A_NONE, rd); chk("R9 unmapped read", rd, 8'h00);

    // R2 R4 R5 R10: sweep all direction patterns
    for (int d = 0; d < 256; d++) begin
      logic [7:0] dv, dat, pv, exp;
      dv  = 8'(d);
      dat = ~dv ^ 8'h3C;
      pv  = 8'(d * 37 + 11);
      bus_write(A_DIR, dv);
      chk("R2 pin_oe", pin_oe, dv);
      bus_write(A_DATA, dat);
      chk("R10 pin_out", pin_out, dat);
      bus_read(A_DATA, rd); chk("R4 data read", rd, dat);
      bus_read(A_DIR, rd); chk("R3 dir read", rd, 8'hFF);
      pin_in = pv;
      @(negedge clk); @(negedge clk);
      exp = (dv & dat) | (~dv & pv);
      bus_read(A_PORT, rd); chk("R5 port read", rd, exp);
    end

    // R6: two-edge input latency
    bus_write(A_DIR, 8'h00);
    pin_in = 8'h00;
    repeat (3) @(negedge clk);
    pin_in = 8'hA5;
    @(negedge clk);
    bus_read(A_PORT, rd); chk("R6 after one edge", rd, 8'h00);
    @(negedge clk);
    bus_read(A_PORT, rd); chk("R6 after two edges", rd, 8'hA5);

    // R8: software standby freezes registers
    bus_write(A_DIR, 8'hF0);
    bus_write(A_DATA, 8'h33);
    @(negedge clk); sw_stby = 1'b1;
    bus_write(A_DATA, 8'hCC);
    bus_write(A_DIR, 8'h0F);
    chk("R8 pin_out held", pin_out, 8'h33);
    chk("R8 pin_oe held", pin_oe, 8'hF0);
    bus_read(A_DATA, rd); chk("R8 data held", rd, 8'h33);
    @(negedge clk); sw_stby = 1'b0;
    chk("R8 pin_oe after exit", pin_oe, 8'hF0);

    // R7: hardware standby clears and releases
    @(negedge clk); hw_stby = 1'b1;
    #1; chk("R7 oe forced low", pin_oe, 8'h00);
    @(negedge clk);
    chk("R7 data cleared", pin_out, 8'h00);
    bus_write(A_DIR, 8'hFF);
    bus_write(A_DATA, 8'hFF);
    chk("R7 write ignored", pin_out, 8'h00);
    hw_stby = 1'b0;
    #1; chk("R7 dir cleared", pin_oe, 8'h00);
    bus_read(A_DATA, rd); chk("R7 data read", rd, 8'h00);

    // R10: normal operation resumes
    bus_write(A_DIR, 8'h5A);
    chk("R10 pin_oe", pin_oe, 8'h5A);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule